// File: doc/BRIEF.md
# Radio Receive Stream Command Controller

This block turns software register writes into a packetized receive sample stream for a single radio channel. Software first programs a per-packet word limit, a 64-bit word count and a 64-bit start time, each 64-bit value as two 32-bit writes. It then writes a command word that starts a finite stream, starts a continuous stream, or stops the running stream. Bit 31 of the command word marks the new stream as timed. A timed stream carries its start time on the first word of its first packet only.

The words come from an internal sample counter. The counter advances by one for each word the consumer accepts, and it keeps counting across streams. The output is a valid/ready stream with start-of-packet and end-of-packet markers and a timestamp-valid flag. Once `m_valid` is high, it stays high and every output field holds its value until the consumer takes the word with `m_ready`. Back-pressure can stall the stream for any number of cycles and drops no words. A stream setting is copied at the moment its command is taken, so later register writes only affect the next stream.

A command that cannot act at once is held as pending. A stop or a new start that arrives while a stream is running takes effect after the end-of-packet of the packet in progress, which is the packet whose words are being offered. An illegal command code does nothing except set a sticky error flag.

Top module: `rx_stream_ctrl`

## Requirements
- R1: After reset `m_valid` and `cmd_err` are low, and the sample counter starts at 0.
- R2: The channel-0 registers sit at byte offsets from base 0x1000: command 0x14, count low 0x18, count high 0x1C, time low 0x20, time high 0x24, packet word limit 0x28 (its low 16 bits). A write anywhere in 0x1080 and above, which decodes to another channel, changes nothing.
- R3: The command code is the written word with bit 31 cleared: 0 stops, 1 starts a finite stream, 2 starts a continuous stream. Bit 31 set makes the started stream timed and does not change the code.
- R4: A finite stream delivers exactly the programmed count of words, then drops `m_valid`. A count of zero starts nothing.
- R5: `m_sop` marks word 0 of every packet. `m_eop` marks the word that reaches the packet word limit, or the final word of a finite stream, so the last packet may be shorter. A limit of 0 acts as 1.
- R6: In a timed stream, only the very first word has `m_ts_valid` high, with `m_ts` equal to the programmed time. An untimed stream never raises `m_ts_valid`.
- R7: A continuous stream sends full-length packets until a stop arrives. On a stop, the packet in progress is completed and the stream then ends.
- R8: A command code above 2 does not start or stop anything. It sets `cmd_err`, which stays high until reset.
- R9: While `m_valid` is high and `m_ready` is low, the next cycle keeps `m_valid` high and keeps `m_data`, `m_sop`, `m_eop`, `m_ts_valid` and `m_ts` unchanged.
- R10: `m_data` equals the number of words accepted since reset, counted over all streams.
- R11: Count, time and word limit are captured when a start command is taken. Writes to them during a stream do not alter that stream.
- R12: A start command during a running stream replaces that stream after the current packet's end-of-packet. The new stream's first word follows directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W (20) | Byte address of the write |
| reg_wdata | input | 32 | Write data |
| m_valid | output | 1 | Output word valid |
| m_ready | input | 1 | Consumer accepts the word |
| m_data | output | DATA_W (32) | Sample word |
| m_sop | output | 1 | First word of a packet |
| m_eop | output | 1 | Last word of a packet |
| m_ts_valid | output | 1 | `m_ts` applies to this word |
| m_ts | output | 64 | Stream start time |
| cmd_err | output | 1 | Sticky flag for an illegal command code |

## Verification
Several properties are checked on every cycle: that the output holds while stalled, that the timestamp appears only on a start-of-packet word, that the word index stays inside the captured limit, that end-of-packet in a continuous stream falls only at full length, that the sample counter advances by one per accepted word, and that the error flag never clears. Only the bench scenarios can show the rest: the exact word totals and packet boundaries of finite streams, the point at which a stop or a replacing start takes effect, the dropping of writes to other channels, and that reprogramming during a stream leaves it unchanged.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
  // Command codes after the timed flag (bit 31) is stripped
  localparam logic [30:0] CODE_STOP   = 31'd0;
  localparam logic [30:0] CODE_FINITE = 31'd1;
  localparam logic [30:0] CODE_CONT   = 31'd2;

  typedef enum logic [1:0] {
    OP_NONE,
    OP_STOP,
    OP_FINITE,
    OP_CONT
  } rxs_op_e;
endpackage

// File: rtl/rxs_regs.sv
module rxs_regs
  import rxs_pkg::*;
#(
  parameter int unsigned ADDR_W     = 20,
  parameter int unsigned BASE_ADDR  = 32'h1000,
  parameter int unsigned CH_STRIDE  = 32'h80,
  parameter int unsigned LEN_W      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  output logic [LEN_W-1:0]  cfg_maxw,
  output logic [63:0]       cfg_count,
  output logic [63:0]       cfg_ts,
  output rxs_op_e           op,
  output logic              op_timed,
  output logic              err
);
  localparam int unsigned OFS_W = $clog2(CH_STRIDE);
  localparam logic [ADDR_W-1:0] BASE_A   = ADDR_W'(BASE_ADDR);
  localparam logic [ADDR_W-1:0] STRIDE_A = ADDR_W'(CH_STRIDE);
  localparam logic [OFS_W-1:0] OFS_CMD   = OFS_W'(8'h14);
  localparam logic [OFS_W-1:0] OFS_CNT_L = OFS_W'(8'h18);
  localparam logic [OFS_W-1:0] OFS_CNT_H = OFS_W'(8'h1C);
  localparam logic [OFS_W-1:0] OFS_TS_L  = OFS_W'(8'h20);
  localparam logic [OFS_W-1:0] OFS_TS_H  = OFS_W'(8'h24);
  localparam logic [OFS_W-1:0] OFS_MAXW  = OFS_W'(8'h28);

  logic [ADDR_W-1:0] rel;
  logic              hit;
  logic [OFS_W-1:0]  ofs;
  logic [30:0]       code;
  logic              cmd_wr;

  assign rel    = wr_addr - BASE_A;
  // only channel 0 (first stride of the window) is decoded
  assign hit    = wr_en && (wr_addr >= BASE_A) && (rel < STRIDE_A);
  assign ofs    = rel[OFS_W-1:0];
  assign code   = wr_data[30:0];
  assign cmd_wr = hit && (ofs == OFS_CMD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_maxw  <= '0;
      cfg_count <= '0;
      cfg_ts    <= '0;
    end else if (hit) begin
      case (ofs)
        OFS_CNT_L: cfg_count[31:0]  <= wr_data;
        OFS_CNT_H: cfg_count[63:32] <= wr_data;
        OFS_TS_L:  cfg_ts[31:0]     <= wr_data;
        OFS_TS_H:  cfg_ts[63:32]    <= wr_data;
        OFS_MAXW:  cfg_maxw         <= wr_data[LEN_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    op       = OP_NONE;
    op_timed = wr_data[31];
    if (cmd_wr) begin
      case (code)
        CODE_STOP:   op = OP_STOP;
        CODE_FINITE: op = OP_FINITE;
        CODE_CONT:   op = OP_CONT;
        default:     op = OP_NONE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      err <= 1'b0;
    else if (cmd_wr && (code > CODE_CONT))
      err <= 1'b1;
  end

  // R8: the error flag never falls once raised
  a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);

  // R8: an illegal code on the channel-0 command register raises the flag
  a_r8_bad_code_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_addr == BASE_A + ADDR_W'(8'h14)) && (wr_data[30:0] > 31'd2)) |=> err);
endmodule

// File: rtl/rxs_sample_src.sv
module rxs_sample_src #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              advance,
  output logic [DATA_W-1:0] sample
);
  always_ff @(posedge clk) begin
    if (!rst_n)
      sample <= '0;
    else if (advance)
      sample <= sample + DATA_W'(1);
  end

  // R10: one step per accepted word, no more
  a_r10_step: assert property (@(posedge clk) disable iff (!rst_n)
    advance |=> (sample == $past(sample) + DATA_W'(1)));
  a_r10_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !advance |=> $stable(sample));
endmodule

// File: rtl/rxs_engine.sv
module rxs_engine
  import rxs_pkg::*;
#(
  parameter int unsigned LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  rxs_op_e          op,
  input  logic             op_timed,
  input  logic [LEN_W-1:0] cfg_maxw,
  input  logic [63:0]      cfg_count,
  input  logic [63:0]      cfg_ts,
  input  logic             m_ready,
  output logic             m_valid,
  output logic             m_sop,
  output logic             m_eop,
  output logic             m_ts_valid,
  output logic [63:0]      m_ts,
  output logic             xfer
);
  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

  typedef struct packed {
    logic             active;
    logic             cont;
    logic             timed;
    logic             first;
    logic [63:0]      remain;
    logic [LEN_W-1:0] idx;
    logic [LEN_W-1:0] maxw;
    logic [63:0]      ts;
  } strm_t;

  typedef struct packed {
    logic             valid;
    logic             cont;
    logic             timed;
    logic [63:0]      count;
    logic [63:0]      ts;
    logic [LEN_W-1:0] maxw;
  } pend_t;

  strm_t s_q, s_d;
  pend_t p_q, p_d;
  logic  stop_q, stop_d;
  logic  last;
  logic  fin_end;

  function automatic strm_t load_strm(input logic cont, input logic timed,
                                      input logic [63:0] cnt, input logic [63:0] ts,
                                      input logic [LEN_W-1:0] mw);
    strm_t s;
    s.active = cont || (cnt != 64'd0);
    s.cont   = cont;
    s.timed  = timed;
    s.first  = 1'b1;
    s.remain = cnt;
    s.idx    = '0;
    s.maxw   = (mw == '0) ? ONE : mw;
    s.ts     = ts;
    return s;
  endfunction

  assign fin_end = !s_q.cont && (s_q.remain == 64'd1);
  assign last    = (s_q.idx == s_q.maxw - ONE) || fin_end;
  assign xfer    = m_valid && m_ready;

  always_comb begin
    s_d    = s_q;
    p_d    = p_q;
    stop_d = stop_q;
    // accepted word
    if (xfer) begin
      s_d.first = 1'b0;
      if (!s_q.cont) s_d.remain = s_q.remain - 64'd1;
      if (last) begin
        s_d.idx = '0;
        stop_d  = 1'b0;
        if (p_q.valid) begin
          s_d       = load_strm(p_q.cont, p_q.timed, p_q.count, p_q.ts, p_q.maxw);
          p_d.valid = 1'b0;
        end else if (stop_q || fin_end) begin
          s_d.active = 1'b0;
        end
      end else begin
        s_d.idx = s_q.idx + ONE;
      end
    end
    // new command, applied on top of the transfer result
    case (op)
      OP_FINITE, OP_CONT: begin
        stop_d = 1'b0;
        if (!s_d.active) begin
          s_d       = load_strm(op == OP_CONT, op_timed, cfg_count, cfg_ts, cfg_maxw);
          p_d.valid = 1'b0;
        end else begin
          p_d.valid = 1'b1;
          p_d.cont  = (op == OP_CONT);
          p_d.timed = op_timed;
          p_d.count = cfg_count;
          p_d.ts    = cfg_ts;
          p_d.maxw  = cfg_maxw;
        end
      end
      OP_STOP: begin
        p_d.valid = 1'b0;
        if (s_d.active) stop_d = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s_q    <= '0;
      p_q    <= '0;
      stop_q <= 1'b0;
    end else begin
      s_q    <= s_d;
      p_q    <= p_d;
      stop_q <= stop_d;
    end
  end

  assign m_valid    = s_q.active;
  assign m_sop      = s_q.active && (s_q.idx == '0);
  assign m_eop      = s_q.active && last;
  assign m_ts_valid = s_q.active && s_q.timed && s_q.first;
  assign m_ts       = s_q.ts;

  // R9: a stalled word keeps every control field
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_sop) && $stable(m_eop)
                               && $stable(m_ts_valid) && $stable(m_ts)));

  // R6: timestamp only rides on a packet start
  a_r6_ts_on_sop: assert property (@(posedge clk) disable iff (!rst_n)
    m_ts_valid |-> m_sop);

  // R6: after the first accepted word the timestamp never reappears in the stream
  a_r6_ts_once: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && !last) |=> !m_ts_valid);

  // R5: word index stays within the captured limit
  a_r5_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> (s_q.idx < s_q.maxw));

  // R7: continuous packets end only at full length
  a_r7_full_len: assert property (@(posedge clk) disable iff (!rst_n)
    (m_eop && s_q.cont) |-> (s_q.idx == s_q.maxw - ONE));

  // R4: a finished finite stream with nothing pending goes idle
  a_r4_finite_done: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && fin_end && !p_q.valid && (op == OP_NONE)) |=> !m_valid);
endmodule

// File: rtl/rx_stream_ctrl.sv
module rx_stream_ctrl
  import rxs_pkg::*;
#(
  parameter int unsigned ADDR_W    = 20,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned LEN_W     = 16,
  parameter int unsigned BASE_ADDR = 32'h1000,
  parameter int unsigned CH_STRIDE = 32'h80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [DATA_W-1:0] m_data,
  output logic              m_sop,
  output logic              m_eop,
  output logic              m_ts_valid,
  output logic [63:0]       m_ts,
  output logic              cmd_err
);
  logic [LEN_W-1:0] cfg_maxw;
  logic [63:0]      cfg_count;
  logic [63:0]      cfg_ts;
  rxs_op_e          op;
  logic             op_timed;
  logic             xfer;

  rxs_regs #(
    .ADDR_W   (ADDR_W),
    .BASE_ADDR(BASE_ADDR),
    .CH_STRIDE(CH_STRIDE),
    .LEN_W    (LEN_W)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (reg_wr),
    .wr_addr  (reg_addr),
    .wr_data  (reg_wdata),
    .cfg_maxw (cfg_maxw),
    .cfg_count(cfg_count),
    .cfg_ts   (cfg_ts),
    .op       (op),
    .op_timed (op_timed),
    .err      (cmd_err)
  );

  rxs_engine #(
    .LEN_W(LEN_W)
  ) u_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .op        (op),
    .op_timed  (op_timed),
    .cfg_maxw  (cfg_maxw),
    .cfg_count (cfg_count),
    .cfg_ts    (cfg_ts),
    .m_ready   (m_ready),
    .m_valid   (m_valid),
    .m_sop     (m_sop),
    .m_eop     (m_eop),
    .m_ts_valid(m_ts_valid),
    .m_ts      (m_ts),
    .xfer      (xfer)
  );

  rxs_sample_src #(
    .DATA_W(DATA_W)
  ) u_src (
    .clk    (clk),
    .rst_n  (rst_n),
    .advance(xfer),
    .sample (m_data)
  );

  // R9: a stalled word keeps its data
  a_r9_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> $stable(m_data));
endmodule

// File: tb/rx_stream_ctrl_bench.sv
module rx_stream_ctrl_bench;
  localparam int ADDR_W = 20;
  localparam int DATA_W = 32;
  localparam logic [ADDR_W-1:0] CH0 = 20'h01000;
  localparam logic [ADDR_W-1:0] A_CMD  = CH0 + 20'h14;
  localparam logic [ADDR_W-1:0] A_CNTL = CH0 + 20'h18;
  localparam logic [ADDR_W-1:0] A_CNTH = CH0 + 20'h1C;
  localparam logic [ADDR_W-1:0] A_TSL  = CH0 + 20'h20;
  localparam logic [ADDR_W-1:0] A_TSH  = CH0 + 20'h24;
  localparam logic [ADDR_W-1:0] A_MAXW = CH0 + 20'h28;

  typedef struct packed {
    logic [31:0] count;
    logic [15:0] maxw;
    logic        timed;
    logic [7:0]  pat;
  } vec_t;

  localparam vec_t VECS [0:5] = '{
    '{32'd10, 16'd4,  1'b0, 8'hFF},
    '{32'd8,  16'd4,  1'b1, 8'hFF},
    '{32'd5,  16'd0,  1'b0, 8'hFF},
    '{32'd7,  16'd3,  1'b1, 8'hA5},
    '{32'd1,  16'd16, 1'b1, 8'h33},
    '{32'd12, 16'd12, 1'b0, 8'h0F}
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              reg_wr = 1'b0;
  logic [ADDR_W-1:0] reg_addr = '0;
  logic [31:0]       reg_wdata = '0;
  logic              m_valid;
  logic              m_ready = 1'b0;
  logic [DATA_W-1:0] m_data;
  logic              m_sop, m_eop, m_ts_valid;
  logic [63:0]       m_ts;
  logic              cmd_err;

  always #10 clk = ~clk;

  rx_stream_ctrl u_rx_stream_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .m_valid(m_valid), .m_ready(m_ready),
    .m_data(m_data), .m_sop(m_sop), .m_eop(m_eop), .m_ts_valid(m_ts_valid),
    .m_ts(m_ts), .cmd_err(cmd_err)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [DATA_W-1:0] r_data [64];
  bit                r_sop [64], r_eop [64], r_tsv [64];
  logic [63:0]       r_ts [64];
  int                r_n;
  int                hold_err;

  logic [DATA_W-1:0] e_data [64];
  bit                e_sop [64], e_eop [64], e_tsv [64];
  logic [63:0]       e_ts [64];
  int                e_n;
  logic [DATA_W-1:0] smp_next = '0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic reg_write(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk);
    m_ready   = 1'b0;
    reg_addr  = a;
    reg_wdata = d;
    reg_wr    = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic setup(input logic [63:0] cnt, input logic [15:0] mw, input logic [63:0] ts);
    reg_write(A_CNTL, cnt[31:0]);
    reg_write(A_CNTH, cnt[63:32]);
    reg_write(A_TSL, ts[31:0]);
    reg_write(A_TSH, ts[63:32]);
    reg_write(A_MAXW, {16'd0, mw});
  endtask

  task automatic add_seg(input int cnt, input int mw, input bit timed, input logic [63:0] ts);
    int eff = (mw == 0) ? 1 : mw;
    for (int k = 0; k < cnt; k++) begin
      e_sop[e_n]  = ((k % eff) == 0);
      e_eop[e_n]  = ((k % eff) == eff - 1) || (k == cnt - 1);
      e_tsv[e_n]  = timed && (k == 0);
      e_ts[e_n]   = ts;
      e_data[e_n] = smp_next;
      smp_next    = smp_next + 1;
      e_n++;
    end
  endtask

  task automatic collect(input int n, input logic [7:0] pat, input int inj_at,
                         input logic [31:0] inj_d);
    bit pv = 1'b0, pr = 1'b0, ps = 1'b0, pe = 1'b0, pt = 1'b0;
    logic [DATA_W-1:0] pd = '0;
    r_n = 0;
    hold_err = 0;
    for (int it = 0; (r_n < n) && (it < 2000); it++) begin
      @(negedge clk);
      if (it == inj_at) begin
        reg_addr = A_CMD; reg_wdata = inj_d; reg_wr = 1'b1;
      end else begin
        reg_wr = 1'b0;
      end
      m_ready = pat[it % 8];
      if (pv && !pr) begin
        if (!m_valid || m_data != pd || m_sop != ps || m_eop != pe || m_ts_valid != pt)
          hold_err++;
      end
      if (m_valid && m_ready) begin
        r_data[r_n] = m_data; r_sop[r_n] = m_sop; r_eop[r_n] = m_eop;
        r_tsv[r_n] = m_ts_valid; r_ts[r_n] = m_ts;
        r_n++;
      end
      pv = m_valid; pr = m_ready; pd = m_data; ps = m_sop; pe = m_eop; pt = m_ts_valid;
    end
    @(negedge clk);
    reg_wr  = 1'b0;
    m_ready = 1'b0;
  endtask

  task automatic compare(input string req);
    int mism = 0;
    for (int k = 0; k < e_n && k < r_n; k++) begin
      if (r_data[k] != e_data[k] || r_sop[k] != e_sop[k] || r_eop[k] != e_eop[k] ||
          r_tsv[k] != e_tsv[k] || (e_tsv[k] && r_ts[k] != e_ts[k]))
        mism++;
    end
    check(r_n == e_n, req, "words delivered", r_n, e_n);
    check(mism == 0, req, "words with wrong data/sop/eop/ts (R5 R6 R10)", mism, 0);
    check(hold_err == 0, "R9", "stall hold violations", hold_err, 0);
  endtask

  initial begin
    #(20 * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run did not finish, actual 1 expected 0");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(m_valid == 1'b0, "R1", "m_valid after reset", m_valid, 0);
    check(cmd_err == 1'b0, "R1", "cmd_err after reset", cmd_err, 0);

    // Vector table: finite streams, R3 flag bit 31, R4, R5, R6, R9, R10
    for (int i = 0; i < 6; i++) begin
      logic [63:0] ts = {32'h0000_A000 + 32'(i), 32'h1234_0000 + 32'(i)};
      setup({32'd0, VECS[i].count}, VECS[i].maxw, ts);
      e_n = 0;
      add_seg(int'(VECS[i].count), int'(VECS[i].maxw), VECS[i].timed, ts);
      reg_write(A_CMD, {VECS[i].timed, 31'd1});
      collect(int'(VECS[i].count), VECS[i].pat, -1, 32'd0);
      compare("R4");
      check(m_valid == 1'b0, "R4", "idle after finite stream", m_valid, 0);
    end

    // R4: zero count starts nothing
    setup(64'd0, 16'd4, 64'd0);
    reg_write(A_CMD, 32'd1);
    repeat (3) @(negedge clk);
    check(m_valid == 1'b0, "R4", "zero-count stream valid", m_valid, 0);

    // R2: channel-1 command and limit writes are dropped
    setup(64'd6, 16'd3, 64'd0);
    reg_write(CH0 + 20'h94, 32'd2);
    repeat (2) @(negedge clk);
    check(m_valid == 1'b0, "R2", "valid after channel-1 command", m_valid, 0);
    reg_write(CH0 + 20'hA8, 32'd1);
    e_n = 0;
    add_seg(6, 3, 1'b0, 64'd0);
    reg_write(A_CMD, 32'd1);
    collect(6, 8'hFF, -1, 32'd0);
    compare("R2");

    // R7 + R3: continuous stream, stop carried with bit 31 set, mid-packet
    setup(64'd0, 16'd4, 64'd0);
    e_n = 0;
    add_seg(8, 4, 1'b0, 64'd0);
    reg_write(A_CMD, 32'd2);
    collect(8, 8'hFF, 5, 32'h8000_0000);
    compare("R7");
    repeat (2) @(negedge clk);
    check(m_valid == 1'b0, "R7", "idle after stop", m_valid, 0);

    // R8: illegal code ignored, error sticky
    reg_write(A_CMD, 32'd3);
    repeat (2) @(negedge clk);
    check(m_valid == 1'b0, "R8", "valid after illegal code", m_valid, 0);
    check(cmd_err == 1'b1, "R8", "cmd_err after illegal code", cmd_err, 1);
    setup(64'd2, 16'd4, 64'd0);
    e_n = 0;
    add_seg(2, 4, 1'b0, 64'd0);
    reg_write(A_CMD, 32'd1);
    collect(2, 8'hFF, -1, 32'd0);
    compare("R8");
    check(cmd_err == 1'b1, "R8", "cmd_err stays set", cmd_err, 1);

    // R11 + R12: reprogram during a stream, then replace it with a timed start
    setup(64'd10, 16'd4, 64'd0);
    reg_write(A_CMD, 32'd1);
    setup(64'd3, 16'd2, 64'h0000_0001_0000_0055);
    e_n = 0;
    add_seg(8, 4, 1'b0, 64'd0);
    add_seg(3, 2, 1'b1, 64'h0000_0001_0000_0055);
    collect(11, 8'hFF, 5, 32'h8000_0001);
    compare("R12");
    check(r_n > 3 && r_eop[3] == 1'b1, "R11", "old stream keeps limit 4", r_n > 3 ? r_eop[3] : 0, 1);
    repeat (2) @(negedge clk);
    check(m_valid == 1'b0, "R12", "idle after replacing stream", m_valid, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule